// File: doc/BRIEF.md
# Roving Test Strip Relocation Sequencer

This controller walks a reserved self-test strip across a column array of configurable logic while the rest of the array keeps working. It starts a test pass in the strip and waits for the strip's test cells to report completion. When the pass is clean, it hands the neighbouring working functions over to the strip's spare cells and commits the strip's new column position. When the pass reports a fault, it stops moving and raises a diagnosis request.

The hand-over runs as a fixed series of steps. The spare cells are first programmed with the working functions while the system clock runs. The system clock is then gated. Register state is copied only when the moved functions hold any. The interconnect is rewired, and the clock is restored. Finally the freed columns are set up as the new strip and a new test pass is started.

The configuration, copy and routing agents sit outside the block behind request/acknowledge pairs. Every request is a one-cycle strobe. An acknowledge that does not arrive within a programmable number of cycles parks the sequencer in a sticky error state with the system clock gated.

Top module: `strip_rove_seq`

## Requirements
- R1: While reset is held and up to the first clock edge after its release, start_test_o is high, sys_clk_en_o is high, pos_o is 0, dir_up_o is 1, and diag_o and err_o are low. From the first edge on, start_test_o is low until the next test launch.
- R2: prog_req_o is asserted only in the cycle after a cycle with test_done_i high and fault_i low. No relocation request appears while test_done_i is low, whatever fault_i is doing.
- R3: If test_done_i and fault_i are both high in a cycle, diag_o goes high from the next cycle and stays high until reset. From then on no request strobe is ever issued and sys_clk_en_o stays high.
- R4: Each of prog_req_o, copy_req_o, route_req_o, strip_req_o and start_test_o is a single-cycle strobe, and at most one of them is high in any cycle. Acknowledges are taken from the cycle after the request onward.
- R5: sys_clk_en_o goes low in the cycle after prog_ack_i is taken. It stays low through the cycle in which route_ack_i is taken and is high again in the next cycle. It is high in every other cycle except in the error state.
- R6: In the single cycle after the programming acknowledge, stateful_i is sampled. If it is high, copy_req_o is strobed in the next cycle and route_req_o follows the copy acknowledge. If it is low, route_req_o is strobed directly in the next cycle and no copy request is issued.
- R7: The cycle after the route acknowledge strobes strip_req_o. The cycle after the strip acknowledge strobes start_test_o, and the sequencer then waits for test_done_i again.
- R8: With a limit L on tmo_limit_i, a step whose acknowledge has not arrived by the L-th cycle after its request enters the error state in the cycle after that. In the error state err_o is high, sys_clk_en_o is low, no strobe is issued and late acknowledges are ignored, until reset.
- R9: Strip positions run from 0 to COLS-STRIP_W. Each completed rewire moves pos_o by one in the direction given by dir_up_o (1 = increasing), visible from the cycle after the route acknowledge. Reaching either end flips dir_up_o in that same update.
- R10: A limit of 0 on tmo_limit_i behaves exactly like a limit of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_done_i | input | 1 | Test pass in the strip has finished |
| fault_i | input | 1 | Test pass found a fault (read with test_done_i) |
| stateful_i | input | 1 | Moved functions hold register state |
| tmo_limit_i | input | TMO_W | Acknowledge timeout in cycles (0 acts as 1) |
| prog_ack_i | input | 1 | Function programming finished |
| copy_ack_i | input | 1 | State copy finished |
| route_ack_i | input | 1 | Rewiring finished |
| strip_ack_i | input | 1 | New strip set up |
| start_test_o | output | 1 | Strobe: launch a test pass |
| prog_req_o | output | 1 | Strobe: program spare cells with working functions |
| copy_req_o | output | 1 | Strobe: copy register state |
| route_req_o | output | 1 | Strobe: rewire interconnect |
| strip_req_o | output | 1 | Strobe: set up freed columns as the strip |
| sys_clk_en_o | output | 1 | System clock enable |
| diag_o | output | 1 | Diagnosis requested (sticky) |
| err_o | output | 1 | Acknowledge timeout (sticky) |
| pos_o | output | $clog2(COLS) | Current strip column |
| dir_up_o | output | 1 | Strip direction, 1 = increasing column |

## Verification
The bench builds the block with COLS=5, STRIP_W=2 and TMO_W=3, which gives strip positions 0 to 3. With only four positions, a long relocation sweep crosses both edges many times, so each direction flip is checked against a position model computed in the bench. The sweep runs every combination of stateful_i and acknowledge delays of 0, 1 and 3 cycles on each step under a limit of 4, so the last delay sits one cycle inside the timeout. Separately, every step is starved under each limit from 0 to 4, which places the error entry cycle for each limit, including the zero case, within a few cycles of the request.

// File: rtl/strip_rove_pkg.sv
package strip_rove_pkg;

    typedef enum logic [3:0] {
        ST_START,
        ST_WAIT_TEST,
        ST_PROG,
        ST_HALT,
        ST_COPY,
        ST_ROUTE,
        ST_STRIP,
        ST_DIAG,
        ST_ERR
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       issued;
    } seq_regs_t;

endpackage

// File: rtl/rove_ack_timer.sv
module rove_ack_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);
    logic [TMO_W-1:0] cnt_d, cnt_q;
    logic [TMO_W:0]   cnt_inc;

    always_comb begin
        cnt_inc   = {1'b0, cnt_q} + 1'b1;
        expired_o = run_i && (cnt_inc >= {1'b0, limit_i});
        cnt_d     = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i && !expired_o) begin
            cnt_d = cnt_inc[TMO_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rove_strip_track.sv
module rove_strip_track #(
    parameter int POS_W    = 4,
    parameter int LAST_POS = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    output logic [POS_W-1:0] pos_o,
    output logic             dir_up_o
);
    localparam logic [POS_W-1:0] LAST_V = POS_W'(LAST_POS);
    localparam logic [POS_W-1:0] ONE_V  = POS_W'(1);

    logic [POS_W-1:0] pos_d, pos_q;
    logic             dir_d, dir_q;

    always_comb begin
        pos_d = pos_q;
        dir_d = dir_q;
        if (advance_i) begin
            if (dir_q) begin
                pos_d = pos_q + 1'b1;
                if (pos_q + 1'b1 == LAST_V) dir_d = 1'b0;
            end else begin
                pos_d = pos_q - 1'b1;
                if (pos_q == ONE_V) dir_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            dir_q <= 1'b1;
        end else begin
            pos_q <= pos_d;
            dir_q <= dir_d;
        end
    end

    assign pos_o    = pos_q;
    assign dir_up_o = dir_q;
endmodule

// File: rtl/strip_rove_seq.sv
module strip_rove_seq
    import strip_rove_pkg::*;
#(
    parameter int COLS    = 16,
    parameter int STRIP_W = 2,
    parameter int TMO_W   = 8,
    localparam int POS_W  = $clog2(COLS),
    localparam int LAST_POS = COLS - STRIP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_done_i,
    input  logic             fault_i,
    input  logic             stateful_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    input  logic             prog_ack_i,
    input  logic             copy_ack_i,
    input  logic             route_ack_i,
    input  logic             strip_ack_i,
    output logic             start_test_o,
    output logic             prog_req_o,
    output logic             copy_req_o,
    output logic             route_req_o,
    output logic             strip_req_o,
    output logic             sys_clk_en_o,
    output logic             diag_o,
    output logic             err_o,
    output logic [POS_W-1:0] pos_o,
    output logic             dir_up_o
);
    seq_regs_t  r_d, r_q;
    logic       step_active;
    logic       req_now;
    logic       waiting;
    logic       step_ack;
    logic       expired;
    logic       advance;
    seq_state_e step_next;

    // step decode: which acknowledge matters and where a completed step leads
    always_comb begin
        step_active = 1'b1;
        step_ack    = 1'b0;
        step_next   = r_q.state;
        case (r_q.state)
            ST_PROG:  begin step_ack = prog_ack_i;  step_next = ST_HALT;  end
            ST_COPY:  begin step_ack = copy_ack_i;  step_next = ST_ROUTE; end
            ST_ROUTE: begin step_ack = route_ack_i; step_next = ST_STRIP; end
            ST_STRIP: begin step_ack = strip_ack_i; step_next = ST_START; end
            default:  step_active = 1'b0;
        endcase
        req_now = step_active && !r_q.issued;
        waiting = step_active && r_q.issued;
        advance = waiting && (r_q.state == ST_ROUTE) && step_ack;
    end

    rove_ack_timer #(.TMO_W(TMO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (req_now),
        .run_i     (waiting && !step_ack),
        .limit_i   (tmo_limit_i),
        .expired_o (expired)
    );

    rove_strip_track #(.POS_W(POS_W), .LAST_POS(LAST_POS)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (advance),
        .pos_o     (pos_o),
        .dir_up_o  (dir_up_o)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_START: begin
                r_d.state  = ST_WAIT_TEST;
                r_d.issued = 1'b0;
            end
            ST_WAIT_TEST: begin
                if (test_done_i) r_d.state = fault_i ? ST_DIAG : ST_PROG;
                r_d.issued = 1'b0;
            end
            ST_PROG, ST_COPY, ST_ROUTE, ST_STRIP: begin
                if (!r_q.issued) begin
                    r_d.issued = 1'b1;
                end else if (step_ack) begin
                    r_d.issued = 1'b0;
                    r_d.state  = step_next;
                end else if (expired) begin
                    r_d.state = ST_ERR;
                end
            end
            ST_HALT: begin
                r_d.state  = stateful_i ? ST_COPY : ST_ROUTE;
                r_d.issued = 1'b0;
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_START;
            r_q.issued <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign start_test_o = (r_q.state == ST_START);
    assign prog_req_o   = req_now && (r_q.state == ST_PROG);
    assign copy_req_o   = req_now && (r_q.state == ST_COPY);
    assign route_req_o  = req_now && (r_q.state == ST_ROUTE);
    assign strip_req_o  = req_now && (r_q.state == ST_STRIP);
    assign sys_clk_en_o = !(r_q.state inside {ST_HALT, ST_COPY, ST_ROUTE, ST_ERR});
    assign diag_o       = (r_q.state == ST_DIAG);
    assign err_o        = (r_q.state == ST_ERR);
endmodule

// File: rtl/strip_rove_chk.sv
module strip_rove_chk #(
    parameter int POS_W    = 4,
    parameter int LAST_POS = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             test_done_i,
    input logic             fault_i,
    input logic             stateful_i,
    input logic             route_ack_i,
    input logic             start_test_o,
    input logic             prog_req_o,
    input logic             copy_req_o,
    input logic             route_req_o,
    input logic             strip_req_o,
    input logic             sys_clk_en_o,
    input logic             diag_o,
    input logic             err_o,
    input logic [POS_W-1:0] pos_o
);
    // R4
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_test_o, prog_req_o, copy_req_o, route_req_o, strip_req_o}));

    // R4
    prog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |=> !prog_req_o);

    // R2
    prog_after_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |-> $past(test_done_i && !fault_i));

    // R5
    prog_clock_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req_o || strip_req_o || start_test_o) |-> sys_clk_en_o);

    // R5
    copy_route_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_req_o || route_req_o) |-> !sys_clk_en_o);

    // R6
    copy_needs_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req_o |-> $past(stateful_i));

    // R3
    diag_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(diag_o) |-> $past(test_done_i && fault_i));

    // R3
    diag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        diag_o |=> diag_o && !prog_req_o);

    // R8
    err_gates_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !sys_clk_en_o && !start_test_o);

    // R9
    pos_moves_on_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pos_o) |-> $past(route_ack_i));

    // R9
    pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_o <= POS_W'(LAST_POS));
endmodule

bind strip_rove_seq strip_rove_chk #(.POS_W(POS_W), .LAST_POS(LAST_POS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .test_done_i  (test_done_i),
    .fault_i      (fault_i),
    .stateful_i   (stateful_i),
    .route_ack_i  (route_ack_i),
    .start_test_o (start_test_o),
    .prog_req_o   (prog_req_o),
    .copy_req_o   (copy_req_o),
    .route_req_o  (route_req_o),
    .strip_req_o  (strip_req_o),
    .sys_clk_en_o (sys_clk_en_o),
    .diag_o       (diag_o),
    .err_o        (err_o),
    .pos_o        (pos_o)
);

// File: tb/strip_rove_seq_test.sv
`timescale 1ns/1ps
module strip_rove_seq_test;
    localparam int COLS    = 5;
    localparam int STRIP_W = 2;
    localparam int TMO_W   = 3;
    localparam int POS_W   = $clog2(COLS);
    localparam int LAST    = COLS - STRIP_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_done_i = 1'b0, fault_i = 1'b0, stateful_i = 1'b0;
    logic [TMO_W-1:0] tmo_limit_i = '0;
    logic prog_ack_i = 1'b0, copy_ack_i = 1'b0, route_ack_i = 1'b0, strip_ack_i = 1'b0;
    logic start_test_o, prog_req_o, copy_req_o, route_req_o, strip_req_o;
    logic sys_clk_en_o, diag_o, err_o, dir_up_o;
    logic [POS_W-1:0] pos_o;

    int vectors = 0;
    int fails = 0;
    int mpos = 0;
    int mdir = 1;

    always #2.5 clk = ~clk;

    strip_rove_seq #(.COLS(COLS), .STRIP_W(STRIP_W), .TMO_W(TMO_W)) uut (
        .clk(clk), .rst_n(rst_n), .test_done_i(test_done_i), .fault_i(fault_i),
        .stateful_i(stateful_i), .tmo_limit_i(tmo_limit_i),
        .prog_ack_i(prog_ack_i), .copy_ack_i(copy_ack_i), .route_ack_i(route_ack_i),
        .strip_ack_i(strip_ack_i), .start_test_o(start_test_o), .prog_req_o(prog_req_o),
        .copy_req_o(copy_req_o), .route_req_o(route_req_o), .strip_req_o(strip_req_o),
        .sys_clk_en_o(sys_clk_en_o), .diag_o(diag_o), .err_o(err_o),
        .pos_o(pos_o), .dir_up_o(dir_up_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic set_ack(input int sel, input logic v);
        case (sel)
            0: prog_ack_i = v;
            1: copy_ack_i = v;
            2: route_ack_i = v;
            default: strip_ack_i = v;
        endcase
    endtask

    function automatic int get_req(input int sel);
        case (sel)
            0: return int'(prog_req_o);
            1: return int'(copy_req_o);
            2: return int'(route_req_o);
            default: return int'(strip_req_o);
        endcase
    endfunction

    function automatic int any_strobe();
        return int'(start_test_o | prog_req_o | copy_req_o | route_req_o | strip_req_o);
    endfunction

    // called in the request cycle; returns in the cycle after the acknowledge
    task automatic handshake(input int sel, input int dly, input int gated);
        tick;
        for (int k = 0; k < dly; k++) begin
            check("R4 strobe lasts one cycle", get_req(sel), 0);
            check("R5 clock enable while waiting", int'(sys_clk_en_o), gated ? 0 : 1);
            tick;
        end
        set_ack(sel, 1'b1);
        tick;
        set_ack(sel, 1'b0);
    endtask

    task automatic do_reset(input int lim);
        rst_n = 1'b0;
        test_done_i = 1'b0; fault_i = 1'b0; stateful_i = 1'b0;
        prog_ack_i = 1'b0; copy_ack_i = 1'b0; route_ack_i = 1'b0; strip_ack_i = 1'b0;
        tmo_limit_i = TMO_W'(lim);
        tick; tick;
        rst_n = 1'b1;
        check("R1 start strobe at reset", int'(start_test_o), 1);
        check("R1 clock enable at reset", int'(sys_clk_en_o), 1);
        check("R1 position at reset", int'(pos_o), 0);
        check("R1 direction at reset", int'(dir_up_o), 1);
        check("R1 flags at reset", int'(diag_o) + int'(err_o), 0);
        tick;
        check("R1 start strobe ends", int'(start_test_o), 0);
        mpos = 0;
        mdir = 1;
    endtask

    task automatic do_move(input int st, input int d0, input int d1, input int d2, input int d3);
        stateful_i = st[0];
        tick;
        check("R2 no relocation before test done", int'(prog_req_o), 0);
        test_done_i = 1'b1;
        tick;
        test_done_i = 1'b0;
        check("R2 programming request after clean pass", int'(prog_req_o), 1);
        check("R5 clock runs while programming", int'(sys_clk_en_o), 1);
        handshake(0, d0, 0);
        check("R5 clock stopped after programming", int'(sys_clk_en_o), 0);
        check("R4 no strobe in stop cycle", any_strobe(), 0);
        tick;
        if (st != 0) begin
            check("R6 copy request when stateful", int'(copy_req_o), 1);
            check("R5 clock stopped during copy", int'(sys_clk_en_o), 0);
            handshake(1, d1, 1);
        end else begin
            check("R6 no copy request when stateless", int'(copy_req_o), 0);
        end
        check("R6 route request", int'(route_req_o), 1);
        check("R5 clock stopped during rewire", int'(sys_clk_en_o), 0);
        handshake(2, d2, 1);
        if (mdir == 1) begin
            mpos++;
            if (mpos == LAST) mdir = 0;
        end else begin
            mpos--;
            if (mpos == 0) mdir = 1;
        end
        check("R5 clock restarted after rewire", int'(sys_clk_en_o), 1);
        check("R7 strip setup request", int'(strip_req_o), 1);
        check("R9 position", int'(pos_o), mpos);
        check("R9 direction", int'(dir_up_o), mdir);
        handshake(3, d3, 0);
        check("R7 test restart strobe", int'(start_test_o), 1);
        tick;
        check("R7 test restart strobe ends", int'(start_test_o), 0);
    endtask

    task automatic tmo_case(input int lim, input int sel);
        int leff;
        leff = (lim == 0) ? 1 : lim;
        do_reset(lim);
        stateful_i = 1'b1;
        test_done_i = 1'b1;
        tick;
        test_done_i = 1'b0;
        if (sel > 0) begin
            handshake(0, 0, 0);
            tick;
            if (sel > 1) begin
                handshake(1, 0, 1);
                if (sel > 2) handshake(2, 0, 1);
            end
        end
        check("R8 starved request issued", get_req(sel), 1);
        tick;
        for (int k = 1; k < leff; k++) tick;
        check(lim == 0 ? "R10 zero limit not yet expired" : "R8 not yet expired", int'(err_o), 0);
        tick;
        check(lim == 0 ? "R10 zero limit expiry" : "R8 expiry cycle", int'(err_o), 1);
        check("R8 clock gated in error", int'(sys_clk_en_o), 0);
        set_ack(sel, 1'b1);
        tick;
        set_ack(sel, 1'b0);
        tick; tick;
        check("R8 error sticky", int'(err_o), 1);
        check("R8 no strobes in error", any_strobe(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int dl[3];
        dl[0] = 0; dl[1] = 1; dl[2] = 3;

        // relocation sweep
        do_reset(4);
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 3; a++)
                for (int b = 0; b < 3; b++)
                    for (int c = 0; c < 3; c++)
                        for (int e = 0; e < 3; e++)
                            do_move(s, dl[a], dl[b], dl[c], dl[e]);

        // fault handling
        do_reset(4);
        fault_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick;
            check("R3 fault ignored without test done", int'(diag_o) + int'(prog_req_o), 0);
        end
        test_done_i = 1'b1;
        tick;
        test_done_i = 1'b0;
        fault_i = 1'b0;
        check("R3 diagnosis entered", int'(diag_o), 1);
        check("R3 no relocation on fault", int'(prog_req_o), 0);
        test_done_i = 1'b1;
        for (int k = 0; k < 5; k++) begin
            tick;
            check("R3 diagnosis sticky", int'(diag_o), 1);
            check("R3 no strobe in diagnosis", any_strobe(), 0);
            check("R3 clock runs in diagnosis", int'(sys_clk_en_o), 1);
        end
        test_done_i = 1'b0;

        // timeout per step and limit
        for (int lim = 0; lim < 5; lim++)
            for (int sel = 0; sel < 4; sel++)
                tmo_case(lim, sel);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule